// File: doc/BRIEF.md
# Packet Classifying Input Arbiter

This block drains packets from a show-ahead input FIFO. Each FIFO entry is a 64-bit data word with an 8-bit control tag. The block sorts every packet by its 16-bit EtherType field and sends the complete packet to one of two downstream ports. IP packets go to the processing port. All other packets go to the bypass port. A system with two input channels places one copy of the block on each channel.

The EtherType arrives in the second word of a packet, so the routing decision cannot be made on the first word. The block therefore pops the header word and the type word into two holding registers. Once it has chosen a port, it replays those two words in order and then streams the rest of the packet straight from the FIFO.

A word is handed over only in a cycle where the chosen port's ready input is high. In that cycle the valid strobe is raised together with the data and control buses.

Top module: `pkt_steer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, neither `ip_vld` nor `byp_vld` is high. `in_rd_en` stays low while the FIFO is empty.
- R2: While no packet is open, a FIFO word whose tag is not 0xFF is popped and dropped. It never appears on either port.
- R3: The header word (tag 0xFF) and the type word are both popped from the FIFO before the header is presented on any port.
- R4: If bits 31:16 of the second word equal 0x0080, every word of the packet is sent on the `ip_*` port.
- R5: Any other value in bits 31:16 of the second word sends every word of the packet on the `byp_*` port.
- R6: A valid strobe is high only in a cycle where that port's ready is high, and the two valid strobes are never high together. Each strobe hands over exactly one word.
- R7: The FIFO is read (`in_rd_en` high, popping the word shown) only when `in_empty` is low. While streaming the packet body, it is read only when the chosen port is ready.
- R8: Words leave the block in FIFO order, with data and tag unchanged. Any pattern of ready stalls causes no loss and no duplication.
- R9: A tag that is neither 0x00 (body word) nor 0xFF ends the packet, including when it is on the second word. In the cycle after the tail word is handed over, no valid strobe is high, and the next word accepted must be a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 64 | FIFO head word, data part |
| in_ctrl | input | 8 | FIFO head word, tag (0xFF header, 0x00 body, other one-hot = tail) |
| in_empty | input | 1 | FIFO holds no word |
| in_rd_en | output | 1 | Pop the FIFO head word |
| ip_data | output | 64 | Processing port data, zero when not valid |
| ip_ctrl | output | 8 | Processing port tag, zero when not valid |
| ip_vld | output | 1 | Processing port word handed over this cycle |
| ip_rdy | input | 1 | Processing port can take a word |
| byp_data | output | 64 | Bypass port data, zero when not valid |
| byp_ctrl | output | 8 | Bypass port tag, zero when not valid |
| byp_vld | output | 1 | Bypass port word handed over this cycle |
| byp_rdy | input | 1 | Bypass port can take a word |

## Verification
The bench uses the default parameters: the type field at bit 16, 16 bits wide, with 0x0080 as the IP code. With these values it can send near misses that a loose compare would let through: 0x0081, the byte-swapped 0x8000 and the common 0x0800. Packet lengths run from two words, where the type word is also the tail, up to nine words, and the tail tag walks through every one-hot position. Ready patterns cover both ports always open, pseudo-random stalls, and one port held shut while traffic flows to the other.

// File: rtl/pkt_steer_pkg.sv
`timescale 1ns/1ps
package pkt_steer_pkg;

    localparam int DATA_W  = 64;
    localparam int CTRL_W  = 8;
    localparam int N_PORTS = 2;
    localparam int N_HOLD  = 2;

    localparam logic [CTRL_W-1:0] TAG_HEAD = '1;
    localparam logic [CTRL_W-1:0] TAG_BODY = '0;

    localparam logic PORT_IP  = 1'b0;
    localparam logic PORT_BYP = 1'b1;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [DATA_W-1:0] data;
    } word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TYPE,
        ST_SEND_HEAD,
        ST_SEND_TYPE,
        ST_FWD
    } state_t;

    typedef enum logic [1:0] {
        SRC_HEAD,
        SRC_TYPE,
        SRC_FIFO
    } src_t;

    function automatic logic is_tail(input logic [CTRL_W-1:0] tag);
        return (tag != TAG_BODY) && (tag != TAG_HEAD);
    endfunction

endpackage

// File: rtl/pkt_steer_hold.sv
`timescale 1ns/1ps
module pkt_steer_hold
    import pkt_steer_pkg::*;
#(
    parameter int SLOTS = N_HOLD
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SLOTS-1:0]         cap,
    input  word_t                    din,
    output word_t [SLOTS-1:0]        slot_q
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)         slot_q[s] <= '0;
            else if (cap[s]) slot_q[s] <= din;
        end
    end
endmodule

// File: rtl/pkt_steer_class.sv
`timescale 1ns/1ps
module pkt_steer_class
    import pkt_steer_pkg::*;
#(
    parameter int               TYPE_LSB = 16,
    parameter int               TYPE_W   = 16,
    parameter logic [TYPE_W-1:0] IP_TYPE = 16'h0080
) (
    input  logic [DATA_W-1:0] data,
    output logic              is_ip
);
    localparam int TYPE_MSB = TYPE_LSB + TYPE_W - 1;

    logic [TYPE_W-1:0] type_field;
    assign type_field = data[TYPE_MSB:TYPE_LSB];
    assign is_ip      = (type_field == IP_TYPE);
endmodule

// File: rtl/pkt_steer_demux.sv
`timescale 1ns/1ps
module pkt_steer_demux
    import pkt_steer_pkg::*;
(
    input  logic                      have,
    input  logic                      sel,
    input  word_t                     word,
    input  logic [N_PORTS-1:0]        rdy,
    output logic [N_PORTS-1:0]        vld,
    output word_t [N_PORTS-1:0]       word_o,
    output logic                      sel_rdy
);
    assign sel_rdy = rdy[sel];

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        assign vld[p]    = have && (sel == p[0]) && rdy[p];
        assign word_o[p] = vld[p] ? word : '0;
    end
endmodule

// File: rtl/pkt_steer_fsm.sv
`timescale 1ns/1ps
module pkt_steer_fsm
    import pkt_steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_empty,
    input  logic [CTRL_W-1:0] fifo_ctrl,
    input  logic              is_ip,
    input  logic              type_tail,
    input  logic              sel_rdy,
    output logic              rd_en,
    output logic [N_HOLD-1:0] cap,
    output src_t              src,
    output logic              have,
    output logic              sel_q
);
    state_t st, st_nxt;

    always_comb begin
        st_nxt = st;
        rd_en  = 1'b0;
        cap    = '0;
        src    = SRC_FIFO;
        have   = 1'b0;
        unique case (st)
            ST_IDLE: begin
                rd_en = !fifo_empty;
                if (!fifo_empty && fifo_ctrl == TAG_HEAD) begin
                    cap[0] = 1'b1;
                    st_nxt = ST_TYPE;
                end
            end
            ST_TYPE: begin
                rd_en = !fifo_empty;
                if (!fifo_empty) begin
                    cap[1] = 1'b1;
                    st_nxt = ST_SEND_HEAD;
                end
            end
            ST_SEND_HEAD: begin
                have = 1'b1;
                src  = SRC_HEAD;
                if (sel_rdy) st_nxt = ST_SEND_TYPE;
            end
            ST_SEND_TYPE: begin
                have = 1'b1;
                src  = SRC_TYPE;
                if (sel_rdy) st_nxt = type_tail ? ST_IDLE : ST_FWD;
            end
            ST_FWD: begin
                have  = !fifo_empty;
                rd_en = !fifo_empty && sel_rdy;
                if (rd_en && is_tail(fifo_ctrl)) st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            sel_q <= PORT_IP;
        end else begin
            st <= st_nxt;
            if (cap[1]) sel_q <= is_ip ? PORT_IP : PORT_BYP;
        end
    end
endmodule

// File: rtl/pkt_steer.sv
`timescale 1ns/1ps
module pkt_steer
    import pkt_steer_pkg::*;
#(
    parameter int               TYPE_LSB = 16,
    parameter int               TYPE_W   = 16,
    parameter logic [TYPE_W-1:0] IP_TYPE = 16'h0080
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CTRL_W-1:0] in_ctrl,
    input  logic              in_empty,
    output logic              in_rd_en,
    output logic [DATA_W-1:0] ip_data,
    output logic [CTRL_W-1:0] ip_ctrl,
    output logic              ip_vld,
    input  logic              ip_rdy,
    output logic [DATA_W-1:0] byp_data,
    output logic [CTRL_W-1:0] byp_ctrl,
    output logic              byp_vld,
    input  logic              byp_rdy
);
    word_t                 fifo_word;
    word_t [N_HOLD-1:0]    held;
    word_t                 out_word;
    word_t [N_PORTS-1:0]   port_word;
    logic  [N_PORTS-1:0]   port_vld;
    logic  [N_PORTS-1:0]   port_rdy;
    logic  [N_HOLD-1:0]    cap;
    logic                  is_ip, sel_rdy, have, sel_q;
    src_t                  src;

    assign fifo_word = '{ctrl: in_ctrl, data: in_data};
    assign port_rdy[PORT_IP]  = ip_rdy;
    assign port_rdy[PORT_BYP] = byp_rdy;

    pkt_steer_hold #(.SLOTS(N_HOLD)) u_hold (
        .clk(clk), .rst(rst), .cap(cap), .din(fifo_word), .slot_q(held)
    );

    pkt_steer_class #(.TYPE_LSB(TYPE_LSB), .TYPE_W(TYPE_W), .IP_TYPE(IP_TYPE)) u_class (
        .data(in_data), .is_ip(is_ip)
    );

    pkt_steer_fsm u_fsm (
        .clk(clk), .rst(rst), .fifo_empty(in_empty), .fifo_ctrl(in_ctrl),
        .is_ip(is_ip), .type_tail(is_tail(held[1].ctrl)), .sel_rdy(sel_rdy),
        .rd_en(in_rd_en), .cap(cap), .src(src), .have(have), .sel_q(sel_q)
    );

    always_comb begin
        unique case (src)
            SRC_HEAD: out_word = held[0];
            SRC_TYPE: out_word = held[1];
            default:  out_word = fifo_word;
        endcase
    end

    pkt_steer_demux u_demux (
        .have(have), .sel(sel_q), .word(out_word), .rdy(port_rdy),
        .vld(port_vld), .word_o(port_word), .sel_rdy(sel_rdy)
    );

    assign ip_vld   = port_vld[PORT_IP];
    assign ip_data  = port_word[PORT_IP].data;
    assign ip_ctrl  = port_word[PORT_IP].ctrl;
    assign byp_vld  = port_vld[PORT_BYP];
    assign byp_data = port_word[PORT_BYP].data;
    assign byp_ctrl = port_word[PORT_BYP].ctrl;
endmodule

// File: rtl/pkt_steer_chk.sv
`timescale 1ns/1ps
module pkt_steer_chk
    import pkt_steer_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_empty,
    input logic              in_rd_en,
    input logic              ip_vld,
    input logic              ip_rdy,
    input logic [CTRL_W-1:0] ip_ctrl,
    input logic              byp_vld,
    input logic              byp_rdy,
    input logic [CTRL_W-1:0] byp_ctrl
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ip_vld && !byp_vld));

    // R6
    one_port_chk: assert property (@(posedge clk) disable iff (rst)
        !(ip_vld && byp_vld));

    // R6
    ip_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ip_vld |-> ip_rdy);

    // R6
    byp_gate_chk: assert property (@(posedge clk) disable iff (rst)
        byp_vld |-> byp_rdy);

    // R7
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        in_rd_en |-> !in_empty);

    // R9
    tail_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ((ip_vld && is_tail(ip_ctrl)) || (byp_vld && is_tail(byp_ctrl)))
        |=> (!ip_vld && !byp_vld));
endmodule

bind pkt_steer pkt_steer_chk u_chk (
    .clk(clk), .rst(rst), .in_empty(in_empty), .in_rd_en(in_rd_en),
    .ip_vld(ip_vld), .ip_rdy(ip_rdy), .ip_ctrl(ip_ctrl),
    .byp_vld(byp_vld), .byp_rdy(byp_rdy), .byp_ctrl(byp_ctrl)
);

// File: tb/pkt_steer_test.sv
`timescale 1ns/1ps
module pkt_steer_test;

    typedef struct {
        logic        port;
        logic [7:0]  ctrl;
        logic [63:0] data;
        int          idx;
    } exp_t;

    typedef struct {
        logic [7:0]  ctrl;
        logic [63:0] data;
    } ent_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] in_data = '0;
    logic [7:0]  in_ctrl = '0;
    logic        in_empty = 1'b1;
    logic        in_rd_en;
    logic [63:0] ip_data, byp_data;
    logic [7:0]  ip_ctrl, byp_ctrl;
    logic        ip_vld, byp_vld;
    logic        ip_rdy = 1'b0;
    logic        byp_rdy = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int popped = 0;
    int pushed = 0;
    int vld_seen = 0;
    int rdy_mode = 0;
    int pkt_id = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic prev_tail = 1'b0;
    logic finished = 1'b0;

    ent_t fifo_q[$];
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    pkt_steer uut (
        .clk(clk), .rst(rst),
        .in_data(in_data), .in_ctrl(in_ctrl), .in_empty(in_empty), .in_rd_en(in_rd_en),
        .ip_data(ip_data), .ip_ctrl(ip_ctrl), .ip_vld(ip_vld), .ip_rdy(ip_rdy),
        .byp_data(byp_data), .byp_ctrl(byp_ctrl), .byp_vld(byp_vld), .byp_rdy(byp_rdy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // FIFO model and ready driver: outputs refreshed just after each edge
    always @(posedge clk) begin
        #0.5;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0: begin ip_rdy = 1'b1;     byp_rdy = 1'b1;     end
            1: begin ip_rdy = lfsr[0];  byp_rdy = lfsr[3];  end
            2: begin ip_rdy = 1'b1;     byp_rdy = 1'b0;     end
            3: begin ip_rdy = 1'b0;     byp_rdy = 1'b1;     end
            default: begin ip_rdy = 1'b0; byp_rdy = 1'b0;   end
        endcase
        in_empty = (fifo_q.size() == 0);
        if (fifo_q.size() != 0) begin
            in_data = fifo_q[0].data;
            in_ctrl = fifo_q[0].ctrl;
        end
    end

    // Monitor: compares handed-over words against the scoreboard
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            if (ip_vld || byp_vld) begin
                logic        port;
                logic [7:0]  c;
                logic [63:0] d;
                exp_t        e;
                vld_seen++;
                // R6
                check(!(ip_vld && byp_vld), "R6", "both valid", {70'd0, ip_vld, byp_vld}, 72'd1);
                check(!ip_vld || ip_rdy, "R6", "ip valid without ready", {71'd0, ip_rdy}, 72'd1);
                check(!byp_vld || byp_rdy, "R6", "byp valid without ready", {71'd0, byp_rdy}, 72'd1);
                port = byp_vld;
                c = byp_vld ? byp_ctrl : ip_ctrl;
                d = byp_vld ? byp_data : ip_data;
                if (exp_q.size() == 0) begin
                    // R2: nothing expected, so a dropped stray leaked out
                    check(1'b0, "R2", "unexpected word", {c, d}, 72'd0);
                end else begin
                    e = exp_q.pop_front();
                    if (e.port == 1'b0)
                        check(port == 1'b0, "R4", "port", {71'd0, port}, 72'd0);
                    else
                        check(port == 1'b1, "R5", "port", {71'd0, port}, 72'd1);
                    // R8
                    check({c, d} == {e.ctrl, e.data}, "R8", "word", {c, d}, {e.ctrl, e.data});
                    if (e.ctrl == 8'hFF) begin
                        // R3
                        check(popped >= e.idx + 2, "R3", "header before type popped",
                              72'(popped), 72'(e.idx + 2));
                    end
                    if (prev_tail) begin
                        // R9
                        check(c == 8'hFF, "R9", "word after tail not header", {64'd0, c}, 72'hFF);
                    end
                end
                prev_tail = (c != 8'h00) && (c != 8'hFF);
            end
        end
    end

    // FIFO pop, after the monitor has looked
    always @(posedge clk) begin
        #1.5;
        if (in_rd_en) begin
            // R7
            check(!in_empty && fifo_q.size() != 0, "R7", "pop while empty",
                  {71'd0, in_empty}, 72'd0);
            if (fifo_q.size() != 0) begin
                void'(fifo_q.pop_front());
                popped++;
            end
        end
    end

    task automatic push_word(input logic [7:0] c, input logic [63:0] d,
                             input bit keep, input logic port);
        exp_t e;
        fifo_q.push_back('{ctrl: c, data: d});
        if (keep) begin
            e.port = port; e.ctrl = c; e.data = d; e.idx = pushed;
            exp_q.push_back(e);
        end
        pushed++;
    endtask

    task automatic send_pkt(input int n_words, input logic [15:0] etype, input logic [7:0] tail);
        logic port;
        port = (etype == 16'h0080) ? 1'b0 : 1'b1;
        pkt_id++;
        for (int w = 0; w < n_words; w++) begin
            logic [7:0]  c;
            logic [63:0] d;
            c = (w == 0) ? 8'hFF : (w == n_words - 1) ? tail : 8'h00;
            d = {16'(pkt_id), 8'(w), 8'h5A, 16'hC3C3, 16'h0F0F};
            if (w == 1) d[31:16] = etype;
            push_word(c, d, 1'b1, port);
        end
    endtask

    task automatic wait_drain(input string req);
        int n;
        n = 0;
        while ((exp_q.size() != 0 || fifo_q.size() != 0) && n < 3000) begin
            @(posedge clk);
            n++;
        end
        repeat (4) @(posedge clk);
        check(exp_q.size() == 0, req, "words missing after drain", 72'(exp_q.size()), 72'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        report();
    end

    initial begin
        rst = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        // R1
        check(!ip_vld && !byp_vld, "R1", "valid during reset", {70'd0, ip_vld, byp_vld}, 72'd0);
        check(!in_rd_en, "R1", "read during reset", {71'd0, in_rd_en}, 72'd0);
        @(posedge clk);
        #2 rst = 1'b0;
        @(posedge clk);
        #1;
        check(!ip_vld && !byp_vld, "R1", "valid after reset", {70'd0, ip_vld, byp_vld}, 72'd0);
        check(!in_rd_en, "R1", "read with empty FIFO", {71'd0, in_rd_en}, 72'd0);

        // R4 / R5 basic
        rdy_mode = 0;
        send_pkt(4, 16'h0080, 8'h80);
        send_pkt(3, 16'h0800, 8'h01);
        wait_drain("R8");

        // R2: stray words only, nothing may come out
        vld_seen = 0;
        push_word(8'h00, 64'hDEAD_0000_0000_0001, 1'b0, 1'b0);
        push_word(8'h04, 64'hDEAD_0000_0000_0002, 1'b0, 1'b0);
        repeat (10) @(posedge clk);
        check(vld_seen == 0, "R2", "stray produced output", 72'(vld_seen), 72'd0);
        check(fifo_q.size() == 0, "R2", "stray not popped", 72'(fifo_q.size()), 72'd0);

        // R9: two-word packets where the type word is the tail
        send_pkt(2, 16'h0080, 8'h10);
        send_pkt(2, 16'h1234, 8'h02);
        send_pkt(5, 16'h0081, 8'h40);
        send_pkt(3, 16'h8000, 8'h08);
        wait_drain("R9");

        // R8: pseudo-random stalls on both ports
        rdy_mode = 1;
        for (int k = 0; k < 24; k++) begin
            logic [15:0] et;
            case (k % 4)
                0: et = 16'h0080;
                1: et = 16'h0800;
                2: et = 16'h0081;
                default: et = 16'h8000;
            endcase
            send_pkt(2 + (k % 8), et, 8'(1 << (k % 8)));
        end
        wait_drain("R8");

        // R4: processing port open, bypass shut
        rdy_mode = 2;
        send_pkt(6, 16'h0080, 8'h20);
        send_pkt(2, 16'h0080, 8'h04);
        wait_drain("R4");

        // R5: bypass open, processing shut
        rdy_mode = 3;
        send_pkt(7, 16'h86DD, 8'h02);
        send_pkt(3, 16'h0000, 8'h80);
        wait_drain("R5");

        report();
    end

endmodule